// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block turns a single pulse-width-modulated command into two gate-enable outputs for the upper and lower switches of a synchronous buck stage. It guarantees that the two enables are never high at once. The analog side supplies digitised comparator flags: switch node low, lower gate discharged, supply above lockout, overvoltage trip and release, and overtemperature trip and release. The block uses these flags to time each handover between the switches.

The dead time is asymmetric. When the upper switch hands over to the lower one, the block waits for the switch node to fall, with no timer. When the lower switch hands over to the upper one, the block waits for the lower gate to discharge, then counts a fixed base delay plus a programmable number of clock cycles. The run input, the supply lockout flag, the overtemperature latch, the overvoltage latch and the lower-side enable each override the sequence in a fixed order of priority. A monitor output reports the lower gate state, and a supply-good output reports that the stage may run.

Top module: `buckgate_seq`

## Requirements
- R1: `gate_hi_o` and `gate_lo_o` are never both high in any cycle.
- R2: With run, supply and lower enable high and no latch active, `gate_hi_o` settles high while PWM is held high and `gate_lo_o` settles high while PWM is held low, provided the handover flags are present.
- R3: After PWM falls, `gate_hi_o` drops 3 rising edges after the pin change. `gate_lo_o` stays low for as long as the switch-node-low flag stays low, and rises on the 3rd rising edge after that flag goes high.
- R4: After PWM rises, `gate_lo_o` drops and `gate_hi_o` stays low for as long as the lower-gate-discharged flag is low. Once that flag goes high (with PWM already seen), `gate_hi_o` rises on rising edge 3 + BASE_DLY + D after the flag pin changes. D is the stored delay setting. If the flag is already high when PWM rises, `gate_hi_o` rises on edge 4 + BASE_DLY + D after the PWM pin change.
- R5: A pulse on `dly_ld_i` stores `dly_val_i` as D on that clock edge, but only while no lower-to-upper handover is pending. A load during a pending handover is dropped entirely, and later handovers still use the old D.
- R6: While the lower enable is low, `gate_lo_o` is low and `ls_mon_o` is high. While it is high, `ls_mon_o` equals `gate_lo_o`.
- R7: While run is low, both gates and `sup_good_o` are low.
- R8: While the supply flag is low, both gates are low. `sup_good_o` is the AND of the run and supply flags, and is low out of reset.
- R9: An overvoltage trip drives `gate_hi_o` low and `gate_lo_o` high 3 rising edges after the trip pin pulse. It needs neither the switch-node flag nor the lower enable. This state holds until the release flag is seen, and trip wins over release. After release the sequence restarts from both gates off, so a high PWM waits out the full R4 handover.
- R10: An overtemperature trip drives both gates low. They stay low until the overtemperature release flag is seen, after which sequencing resumes.
- R11: Priority from highest to lowest is run, supply, overtemperature, overvoltage, lower enable, normal sequencing. An active overvoltage latch therefore drives both gates low when run is low, when the supply is low or when overtemperature is active.
- R12: Every input except `dly_ld_i` and `dly_val_i` passes two synchronising flops, so a pin change first affects the outputs after the second rising edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | PWM command |
| run_i | input | 1 | High to run; low shuts the stage down |
| sup_ok_i | input | 1 | Supply above lockout threshold |
| ls_en_i | input | 1 | Lower switch enable |
| sw_low_i | input | 1 | Switch node below about 1 V |
| lg_low_i | input | 1 | Lower gate below 10 % of supply |
| ov_trip_i | input | 1 | Overvoltage trip |
| ov_rel_i | input | 1 | Overvoltage release (sense below 0.4 V) |
| ot_trip_i | input | 1 | Overtemperature trip |
| ot_rel_i | input | 1 | Overtemperature release after hysteresis |
| dly_ld_i | input | 1 | Load strobe for the delay setting |
| dly_val_i | input | DLY_W | Delay setting value (extra cycles) |
| gate_hi_o | output | 1 | Upper switch gate enable |
| gate_lo_o | output | 1 | Lower switch gate enable |
| ls_mon_o | output | 1 | Lower switch monitor |
| sup_good_o | output | 1 | Supply good |

## Verification
The bench measures the exact edge on which each gate moves during both handovers. A design that counts the delay one cycle short, or that skips the wait for a flag, moves a gate one edge early or turns the lower gate on with no switch-node flag present. A delay load is issued in the middle of a pending handover. A design that accepts that load stretches the next handover by the wrong amount. The bench also overlaps the protection sources and releases them one at a time. A design that lets overvoltage win over overtemperature, or that resumes from its old state after release, leaves the lower gate high or brings the upper gate on without a fresh delay.

// File: rtl/buckgate_pkg.sv
package buckgate_pkg;

   // index of each synchronised input inside the flag vector
   localparam int FI_PWM  = 0;
   localparam int FI_RUN  = 1;
   localparam int FI_SUP  = 2;
   localparam int FI_LSEN = 3;
   localparam int FI_SW   = 4;
   localparam int FI_LG   = 5;
   localparam int FI_OVT  = 6;
   localparam int FI_OVR  = 7;
   localparam int FI_OTT  = 8;
   localparam int FI_OTR  = 9;
   localparam int FI_NUM  = 10;

   typedef enum logic [2:0] {
      ST_OFF,    // both gates off, sequence restart point
      ST_HI,     // upper switch on
      ST_WSW,    // upper off, waiting for switch node low
      ST_LO,     // lower switch on
      ST_WLG,    // lower off, waiting for lower gate discharged
      ST_DLY     // counting the programmed dead time
   } seq_st_t;

endpackage

// File: rtl/buckgate_sync.sv
module buckgate_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("buckgate_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("buckgate_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/buckgate_latch.sv
module buckgate_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic rel_i,
   output logic act_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     act_o <= 1'b0;
      else if (set_i) act_o <= 1'b1;
      else if (rel_i) act_o <= 1'b0;
   end

   // R9
   trip_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> act_o);

endmodule

// File: rtl/buckgate_seq_fsm.sv
module buckgate_seq_fsm
   import buckgate_pkg::*;
#(
   parameter int BASE_DLY = 5,
   parameter int DLY_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_i,
   input  logic             sw_low_i,
   input  logic             lg_low_i,
   input  logic             hold_off_i,
   input  logic             dly_ld_i,
   input  logic [DLY_W-1:0] dly_val_i,
   output logic             hi_req_o,
   output logic             lo_req_o
);

   localparam int TOT_MAX = BASE_DLY + (1 << DLY_W) - 1;
   localparam int CNT_W   = $clog2(TOT_MAX + 1);

   if (BASE_DLY < 1) begin : g_bad_base
      $error("buckgate_seq_fsm: BASE_DLY must be at least 1");
   end
   if (DLY_W < 1 || DLY_W > 16) begin : g_bad_dw
      $error("buckgate_seq_fsm: DLY_W out of range");
   end

   seq_st_t          st_q, st_nx;
   logic [CNT_W-1:0] cnt_q, cnt_nx;
   logic [DLY_W-1:0] dly_q;
   logic             busy;

   assign busy = (st_q == ST_WLG) || (st_q == ST_DLY);

   // delay setting only accepted while no upward handover is pending
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 dly_q <= '0;
      else if (dly_ld_i && !busy) dly_q <= dly_val_i;
   end

   always_comb begin
      st_nx  = st_q;
      cnt_nx = cnt_q;
      if (hold_off_i) begin
         st_nx = ST_OFF;
      end else begin
         unique case (st_q)
            ST_OFF: st_nx = pwm_i ? ST_WLG : ST_WSW;
            ST_HI:  if (!pwm_i) st_nx = ST_WSW;
            ST_WSW: begin
               if (pwm_i)         st_nx = ST_WLG;
               else if (sw_low_i) st_nx = ST_LO;
            end
            ST_LO:  if (pwm_i) st_nx = ST_WLG;
            ST_WLG: begin
               if (!pwm_i) begin
                  st_nx = ST_WSW;
               end else if (lg_low_i) begin
                  st_nx  = ST_DLY;
                  cnt_nx = CNT_W'(BASE_DLY - 1) + CNT_W'(dly_q);
               end
            end
            ST_DLY: begin
               if (!pwm_i)           st_nx = ST_WSW;
               else if (cnt_q == '0) st_nx = ST_HI;
               else                  cnt_nx = cnt_q - 1'b1;
            end
            default: st_nx = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_OFF;
         cnt_q <= '0;
      end else begin
         st_q  <= st_nx;
         cnt_q <= cnt_nx;
      end
   end

   assign hi_req_o = (st_q == ST_HI);
   assign lo_req_o = (st_q == ST_LO);

   // R3
   lo_needs_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_req_o) |-> $past(sw_low_i));

   // R4
   hi_after_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_req_o) |-> ($past(st_q == ST_DLY) && $past(cnt_q == '0)));

   // R5
   dly_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(dly_q));

endmodule

// File: rtl/buckgate_seq.sv
module buckgate_seq
   import buckgate_pkg::*;
#(
   parameter int BASE_DLY    = 5,
   parameter int DLY_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_i,
   input  logic             run_i,
   input  logic             sup_ok_i,
   input  logic             ls_en_i,
   input  logic             sw_low_i,
   input  logic             lg_low_i,
   input  logic             ov_trip_i,
   input  logic             ov_rel_i,
   input  logic             ot_trip_i,
   input  logic             ot_rel_i,
   input  logic             dly_ld_i,
   input  logic [DLY_W-1:0] dly_val_i,
   output logic             gate_hi_o,
   output logic             gate_lo_o,
   output logic             ls_mon_o,
   output logic             sup_good_o
);

   logic [FI_NUM-1:0] raw_flags, s_flags;
   logic ov_act, ot_act, block, hold, hi_req, lo_req;

   always_comb begin
      raw_flags          = '0;
      raw_flags[FI_PWM]  = pwm_i;
      raw_flags[FI_RUN]  = run_i;
      raw_flags[FI_SUP]  = sup_ok_i;
      raw_flags[FI_LSEN] = ls_en_i;
      raw_flags[FI_SW]   = sw_low_i;
      raw_flags[FI_LG]   = lg_low_i;
      raw_flags[FI_OVT]  = ov_trip_i;
      raw_flags[FI_OVR]  = ov_rel_i;
      raw_flags[FI_OTT]  = ot_trip_i;
      raw_flags[FI_OTR]  = ot_rel_i;
   end

   buckgate_sync #(.WIDTH(FI_NUM), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_flags),
      .q_o   (s_flags)
   );

   buckgate_latch ov_latch_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (s_flags[FI_OVT]),
      .rel_i (s_flags[FI_OVR]),
      .act_o (ov_act)
   );

   buckgate_latch ot_latch_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (s_flags[FI_OTT]),
      .rel_i (s_flags[FI_OTR]),
      .act_o (ot_act)
   );

   // overrides that force both gates off, ahead of overvoltage
   assign block = !s_flags[FI_RUN] || !s_flags[FI_SUP] || ot_act;
   assign hold  = block || ov_act;

   buckgate_seq_fsm #(.BASE_DLY(BASE_DLY), .DLY_W(DLY_W)) fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwm_i      (s_flags[FI_PWM]),
      .sw_low_i   (s_flags[FI_SW]),
      .lg_low_i   (s_flags[FI_LG]),
      .hold_off_i (hold),
      .dly_ld_i   (dly_ld_i),
      .dly_val_i  (dly_val_i),
      .hi_req_o   (hi_req),
      .lo_req_o   (lo_req)
   );

   assign gate_hi_o  = hi_req && !hold;
   assign gate_lo_o  = !block && (ov_act || (s_flags[FI_LSEN] && lo_req));
   assign ls_mon_o   = s_flags[FI_LSEN] ? gate_lo_o : 1'b1;
   assign sup_good_o = s_flags[FI_RUN] && s_flags[FI_SUP];

   // R1
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi_o && gate_lo_o));

   // R9
   ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ov_act) |-> $past(s_flags[FI_OVR]));

   // R10
   ot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ot_act) |-> $past(s_flags[FI_OTR]));

   // R10
   ot_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ot_act) && ot_act) |-> (!gate_hi_o && !gate_lo_o));

endmodule

// File: tb/buckgate_seq_tb.sv
module buckgate_seq_tb_top;

   localparam int BASE = 5;
   localparam int DW   = 8;
   // bench-side flag order
   localparam int B_PWM = 0, B_RUN = 1, B_SUP = 2, B_LSEN = 3, B_SW = 4,
                  B_LG = 5, B_OVT = 6, B_OVR = 7, B_OTT = 8, B_OTR = 9;
   localparam int M_OFF = 0, M_HI = 1, M_WSW = 2, M_LO = 3, M_WLG = 4, M_DLY = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm = 0, run = 0, sup = 0, lsen = 0, swl = 0, lgl = 0;
   logic ovt = 0, ovr = 0, ott = 0, otr = 0, dld = 0;
   logic [DW-1:0] dval = '0;
   logic gh, gl, mon, good;

   int checks = 0;
   int fails  = 0;
   bit cmp_on = 0;
   string cur_req = "R8";

   always #2 clk = ~clk;

   buckgate_seq #(.BASE_DLY(BASE), .DLY_W(DW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .run_i(run), .sup_ok_i(sup),
      .ls_en_i(lsen), .sw_low_i(swl), .lg_low_i(lgl), .ov_trip_i(ovt),
      .ov_rel_i(ovr), .ot_trip_i(ott), .ot_rel_i(otr), .dly_ld_i(dld),
      .dly_val_i(dval), .gate_hi_o(gh), .gate_lo_o(gl), .ls_mon_o(mon),
      .sup_good_o(good)
   );

   // ---------------- behavioural reference ----------------
   logic [9:0] q1 = '0, q2 = '0;
   int  m_st = M_OFF, m_cnt = 0, m_dly = 0;
   bit  m_ov = 0, m_ot = 0;

   always @(posedge clk) begin : model
      bit blk, hld, busy;
      int nst, ncnt;
      if (!rst_n) begin
         q1 = '0; q2 = '0; m_st = M_OFF; m_cnt = 0; m_dly = 0; m_ov = 0; m_ot = 0;
      end else begin
         blk  = !q2[B_RUN] || !q2[B_SUP] || m_ot;
         hld  = blk || m_ov;
         busy = (m_st == M_WLG) || (m_st == M_DLY);
         nst  = m_st; ncnt = m_cnt;
         if (hld) nst = M_OFF;
         else if (m_st == M_OFF) nst = q2[B_PWM] ? M_WLG : M_WSW;
         else if (m_st == M_HI) begin if (!q2[B_PWM]) nst = M_WSW; end
         else if (m_st == M_WSW) begin
            if (q2[B_PWM]) nst = M_WLG; else if (q2[B_SW]) nst = M_LO;
         end
         else if (m_st == M_LO) begin if (q2[B_PWM]) nst = M_WLG; end
         else if (m_st == M_WLG) begin
            if (!q2[B_PWM]) nst = M_WSW;
            else if (q2[B_LG]) begin nst = M_DLY; ncnt = BASE + m_dly; end
         end
         else begin
            if (!q2[B_PWM]) nst = M_WSW;
            else begin ncnt = m_cnt - 1; if (ncnt == 0) nst = M_HI; end
         end
         if (dld && !busy) m_dly = dval;
         if (q2[B_OVT]) m_ov = 1; else if (q2[B_OVR]) m_ov = 0;
         if (q2[B_OTT]) m_ot = 1; else if (q2[B_OTR]) m_ot = 0;
         q2 = q1;
         q1 = {otr, ott, ovr, ovt, lgl, swl, lsen, sup, run, pwm};
         m_st = nst; m_cnt = ncnt;
      end
   end

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin : compare
      bit blk, hld, egh, egl;
      if (cmp_on) begin
         blk = !q2[B_RUN] || !q2[B_SUP] || m_ot;
         hld = blk || m_ov;
         egh = !hld && (m_st == M_HI);
         egl = !blk && (m_ov || (q2[B_LSEN] && m_st == M_LO));
         chk("R1", "no overlap", gh && gl, 1'b0);
         chk(cur_req, "model gate_hi", gh, egh);
         chk(cur_req, "model gate_lo", gl, egl);
         chk(cur_req, "model monitor", mon, q2[B_LSEN] ? egl : 1'b1);
         chk(cur_req, "model good", good, q2[B_RUN] && q2[B_SUP]);
      end
   end

   task automatic tick(int n); repeat (n) @(posedge clk); #1; endtask
   task automatic look(int k); repeat (k) @(posedge clk); @(negedge clk); endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   localparam int T0 = BASE;
   localparam int T7 = BASE + 7;

   initial begin : stim
      tick(2); cmp_on = 1;
      tick(2);
      look(0);
      chk("R8", "reset good", good, 1'b0);
      chk("R8", "reset gate_hi", gh, 1'b0);
      chk("R8", "reset gate_lo", gl, 1'b0);
      chk("R6", "reset monitor", mon, 1'b1);
      tick(1); rst_n = 1;

      cur_req = "R2";
      tick(1); run = 1; sup = 1; lsen = 1; swl = 1; lgl = 1; pwm = 0;
      tick(10); look(0);
      chk("R2", "low on while pwm low", gl, 1'b1);
      chk("R8", "good with run and supply", good, 1'b1);
      tick(1); pwm = 1;
      tick(30); look(0);
      chk("R2", "high on while pwm high", gh, 1'b1);
      chk("R2", "low off while pwm high", gl, 1'b0);

      // falling handover
      cur_req = "R3";
      tick(1); pwm = 0; swl = 0;
      look(2); chk("R3", "high still on edge 2", gh, 1'b1);
      look(1); chk("R3", "high off edge 3", gh, 1'b0);
      chk("R3", "low waits switch flag", gl, 1'b0);
      tick(20); look(0); chk("R3", "no timer on low side", gl, 1'b0);
      tick(1); swl = 1;
      look(2); chk("R3", "low off edge 2", gl, 1'b0);
      look(1); chk("R3", "low on edge 3", gl, 1'b1);

      // rising handover with flag late
      cur_req = "R4";
      tick(5); lgl = 0; pwm = 1;
      tick(20); look(0);
      chk("R4", "high waits gate flag", gh, 1'b0);
      chk("R4", "low off on rise", gl, 1'b0);
      tick(1); lgl = 1;
      look(2 + T0); chk("R4", "high off before delay end", gh, 1'b0);
      look(1);      chk("R4", "high on after delay", gh, 1'b1);

      // delay setting
      cur_req = "R5";
      tick(1); pwm = 0;
      tick(10); dld = 1; dval = 8'd7;
      tick(1); dld = 0;
      tick(3); pwm = 1;
      look(3 + T7); chk("R5", "high off before delay 7", gh, 1'b0);
      look(1);      chk("R5", "high on after delay 7", gh, 1'b1);
      tick(1); pwm = 0;
      tick(10); pwm = 1;
      tick(6); dld = 1; dval = 8'd50;
      tick(1); dld = 0;
      tick(20); pwm = 0;
      tick(10); pwm = 1;
      look(3 + T7); chk("R5", "busy load ignored, off", gh, 1'b0);
      look(1);      chk("R5", "busy load ignored, on", gh, 1'b1);

      // lower enable
      cur_req = "R6";
      tick(1); pwm = 0;
      tick(10); lsen = 0;
      look(1); chk("R12", "low still on edge 1", gl, 1'b1);
      look(1); chk("R6", "low forced off", gl, 1'b0);
      chk("R6", "monitor high when disabled", mon, 1'b1);
      tick(1); lsen = 1;
      tick(4); look(0);
      chk("R6", "monitor follows low gate", mon, 1'b1);
      chk("R6", "low back on", gl, 1'b1);
      tick(1); pwm = 1;
      tick(30); look(0);
      chk("R6", "monitor low with low gate", mon, 1'b0);

      // overvoltage
      cur_req = "R9";
      tick(1); swl = 0; ovt = 1;
      tick(1); ovt = 0;
      look(1); chk("R9", "high before trip seen", gh, 1'b1);
      look(1); chk("R9", "high off on trip", gh, 1'b0);
      chk("R9", "low on without switch flag", gl, 1'b1);
      tick(1); lsen = 0;
      tick(20); look(0);
      chk("R9", "low held with enable low", gl, 1'b1);
      chk("R9", "high held off", gh, 1'b0);
      tick(1); ovr = 1;
      tick(1); ovr = 0;
      look(1); chk("R9", "held until release seen", gl, 1'b1);
      look(1); chk("R9", "low off after release", gl, 1'b0);
      look(1 + T7); chk("R9", "restart waits delay", gh, 1'b0);
      look(1); chk("R9", "restart high on", gh, 1'b1);
      tick(1); lsen = 1; swl = 1;

      // overtemperature
      cur_req = "R10";
      tick(1); ott = 1;
      tick(1); ott = 0;
      look(2); chk("R10", "high off on over-temp", gh, 1'b0);
      chk("R10", "low off on over-temp", gl, 1'b0);
      tick(1); pwm = 0;
      tick(20); look(0);
      chk("R10", "low held off", gl, 1'b0);
      chk("R10", "good unaffected", good, 1'b1);
      tick(1); otr = 1;
      tick(1); otr = 0;
      tick(10); look(0);
      chk("R10", "low resumes after release", gl, 1'b1);

      // priority
      cur_req = "R11";
      tick(1); ott = 1; ovt = 1;
      tick(1); ott = 0; ovt = 0;
      tick(5); look(0);
      chk("R11", "over-temp beats overvoltage", gl, 1'b0);
      tick(1); otr = 1;
      tick(1); otr = 0;
      tick(5); look(0);
      chk("R11", "overvoltage after over-temp release", gl, 1'b1);
      tick(1); run = 0;
      tick(5); look(0);
      chk("R11", "run beats overvoltage", gl, 1'b0);
      tick(1); run = 1; sup = 0;
      tick(5); look(0);
      chk("R11", "supply beats overvoltage", gl, 1'b0);
      chk("R8", "good low with supply low", good, 1'b0);
      tick(1); sup = 1; ovr = 1;
      tick(1); ovr = 0; pwm = 1;
      tick(40); look(0);
      chk("R2", "high after all releases", gh, 1'b1);

      // shutdown and latency
      cur_req = "R7";
      tick(1); run = 0;
      look(1); chk("R12", "good still high edge 1", good, 1'b1);
      look(1); chk("R7", "good low on shutdown", good, 1'b0);
      chk("R7", "high off on shutdown", gh, 1'b0);
      tick(10); look(0); chk("R7", "low off on shutdown", gl, 1'b0);
      tick(1); run = 1;
      cur_req = "R8";
      tick(30); sup = 0;
      tick(5); look(0);
      chk("R8", "high off on lockout", gh, 1'b0);
      chk("R8", "good off on lockout", good, 1'b0);
      tick(1); sup = 1;

      // random sweep
      cur_req = "R2";
      for (int i = 0; i < 4000; i++) begin
         tick(1);
         if ($urandom_range(7) == 0) pwm = ~pwm;
         swl  = $urandom_range(1);
         lgl  = $urandom_range(3) != 0;
         lsen = $urandom_range(9) != 0;
         ovt  = $urandom_range(199) == 0;
         ovr  = $urandom_range(19) == 0;
         ott  = $urandom_range(299) == 0;
         otr  = $urandom_range(19) == 0;
         run  = $urandom_range(149) != 0;
         sup  = $urandom_range(149) != 0;
         dld  = $urandom_range(15) == 0;
         dval = 8'($urandom_range(7));
      end
      tick(5);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule